// File: doc/BRIEF.md
# Binary64 Pack and Round Stage

This block turns an unpacked floating-point result into a 64-bit IEEE-754 binary64 word. Its input is a sign bit, a signed unbiased exponent and a 55-bit integer mantissa. A normalized mantissa has its top bit (bit 54) set. Bit 0 is a sticky bit: the OR of every bit that an earlier stage shifted out below it. The value the input stands for is (-1)^sign × mantissa × 2^exponent.

The stage rounds to nearest with ties to even. Any result below the smallest normal magnitude is flushed to a zero that keeps the input sign. Infinities, NaNs and exponent overflow are not handled, and an overflowing exponent gives an unspecified word.

The stage is a single registered pipeline step. A word entered with `in_valid` high appears one clock later, with `out_valid` high. It sits at the end of an arithmetic datapath (adder, multiplier, divider) whose normalizer produces the 55-bit mantissa.

Top module: `b64_pack_round`

## Requirements
- R1: For an exponent e of at least -1076 and a mantissa with bit 54 set, the output word is laid out as follows, unless rounding carries:
  - bit 63 holds the sign;
  - bits 62..52 hold the biased exponent e + 1077 (bias 1023);
  - bits 51..0 hold mantissa bits 53..2.
- R2: When mantissa bit 1 (the guard bit) is 0, the fraction is the truncated mantissa bits 53..2, with no increment.
- R3: When mantissa bits 1 and 0 are both 1, the packed word is incremented by one.
- R4: When mantissa bits 1..0 are 10 (an exact tie), the word is incremented only if mantissa bit 2 (the kept LSB) is 1.
- R5: A rounding increment that carries out of the fraction raises the exponent field by one and leaves the fraction zero. An all-ones mantissa with e = -54 gives 2.0 (0x4000000000000000).
- R6: An exponent below -1076 gives a signed zero: bit 63 equals the sign and bits 62..0 are zero.
- R7: An exponent of exactly -1076 with a normalized mantissa gives biased exponent field 1, the smallest normal.
- R8: A zero mantissa gives a signed zero for any exponent.
- R9: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.
- R10: While `in_valid` is low, `out_data` keeps its last value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operands are valid this cycle |
| in_sign | input | 1 | Sign of the value, 1 for negative |
| in_exp | input | 16 | Unbiased exponent, two's complement |
| in_mant | input | 55 | Integer mantissa, bit 0 sticky |
| out_valid | output | 1 | `out_data` holds a new result |
| out_data | output | 64 | Packed binary64 word |

## Verification
The bench builds the block with its default widths: a 16-bit two's-complement exponent, a 55-bit mantissa and a 64-bit output word. With these widths the 1076 offset and the flush test are carried out at a width where every exponent between -1100 and +900 is represented exactly. That range covers both sides of the -1076/-1077 boundary and the large positive values. The full 55-bit mantissa keeps the guard, sticky and kept-LSB combinations, including the carry out of an all-ones fraction, reachable from the ports.

// File: rtl/b64_pack_pkg.sv
package b64_pack_pkg;

    localparam int EXP_W      = 16;
    localparam int MANT_W     = 55;
    localparam int WORD_W     = 64;
    localparam int FRAC_W     = 52;
    localparam int EXP_OFFSET = 1076;

    // Bit f of this constant says whether low mantissa bits f = m[2:0]
    // call for an increment: set at 3 (011), 6 (110) and 7 (111).
    localparam logic [7:0] ROUND_LUT = 8'hC8;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp_field;
        logic [MANT_W-1:0] mant;
    } unpacked_t;

    function automatic logic round_up(input logic [2:0] low_bits);
        return ROUND_LUT[low_bits];
    endfunction

endpackage

// File: rtl/b64_exp_clamp.sv
module b64_exp_clamp
    import b64_pack_pkg::*;
#(
    parameter int EW     = EXP_W,
    parameter int MW     = MANT_W,
    parameter int OFFSET = EXP_OFFSET
) (
    input  logic                 sign_i,
    input  logic signed [EW-1:0] exp_i,
    input  logic [MW-1:0]        mant_i,
    output unpacked_t            res_o
);

    logic signed [EW-1:0] exp_adj;
    logic                 below_normal;
    logic [MW-1:0]        mant_kept;
    logic                 has_lead;

    always_comb begin
        exp_adj      = exp_i + EW'(OFFSET);
        below_normal = exp_adj[EW-1];
        mant_kept    = below_normal ? '0 : mant_i;
        has_lead     = mant_kept[MW-1];
        res_o.sign      = sign_i;
        res_o.mant      = mant_kept;
        res_o.exp_field = has_lead ? exp_adj : '0;
    end

endmodule

// File: rtl/b64_round_pack.sv
module b64_round_pack
    import b64_pack_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int FW = FRAC_W
) (
    input  unpacked_t       res_i,
    output logic [WW-1:0]   word_o
);

    logic [WW-1:0] base;
    logic [WW-1:0] with_exp;
    logic          inc;

    always_comb begin
        base     = {res_i.sign, {(WW-1){1'b0}}} | WW'(res_i.mant >> 2);
        // The mantissa's leading one lands on the exponent LSB and adds one.
        with_exp = base + (WW'(res_i.exp_field) << FW);
        inc      = round_up(res_i.mant[2:0]);
        word_o   = with_exp + WW'(inc);
    end

endmodule

// File: rtl/b64_pack_round.sv
module b64_pack_round
    import b64_pack_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MANT_W,
    parameter int WW = WORD_W,
    parameter int FW = FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sign,
    input  logic signed [EW-1:0] in_exp,
    input  logic [MW-1:0]        in_mant,
    output logic                 out_valid,
    output logic [WW-1:0]        out_data
);

    unpacked_t     clamped;
    logic [WW-1:0] packed_word;

    b64_exp_clamp #(.EW(EW), .MW(MW), .OFFSET(EXP_OFFSET)) u_clamp (
        .sign_i (in_sign),
        .exp_i  (in_exp),
        .mant_i (in_mant),
        .res_o  (clamped)
    );

    b64_round_pack #(.WW(WW), .FW(FW)) u_pack (
        .res_i  (clamped),
        .word_o (packed_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= packed_word;
            end
        end
    end

    logic in_normal;
    logic no_inc_case;
    assign in_normal   = in_mant[MW-1] && (int'(in_exp) >= -EXP_OFFSET);
    assign no_inc_case = !(in_mant[1] && (in_mant[0] || in_mant[2]));

    assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    assert_truncate_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_normal && no_inc_case |=>
            out_data[FW-1:0] == $past(in_mant[FW+1:2]));

    assert_carry_exp_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_normal && (&in_mant) |=> out_data[FW-1:0] == '0);

    assert_flush_low_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && (int'(in_exp) < -EXP_OFFSET) |=>
            out_data == {$past(in_sign), {(WW-1){1'b0}}});

    assert_zero_mant_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_mant == '0) |=>
            out_data == {$past(in_sign), {(WW-1){1'b0}}});

endmodule

// File: tb/b64_pack_round_bench.sv
module b64_pack_round_bench;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic               in_sign;
    logic signed [15:0] in_exp;
    logic [54:0]        in_mant;
    logic               out_valid;
    logic [63:0]        out_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    b64_pack_round u_b64_pack_round (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sign   (in_sign),
        .in_exp    (in_exp),
        .in_mant   (in_mant),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct packed {
        logic        s;
        logic [15:0] e;
        logic [54:0] m;
        logic [63:0] x;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 16'hFFCA, 55'h40000000000000, 64'h3FF0000000000000}, // R1 1.0
        '{1'b1, 16'hFFCB, 55'h40000000000000, 64'hC000000000000000}, // R1 -2.0
        '{1'b0, 16'hFFCA, 55'h60000000000000, 64'h3FF8000000000000}, // R1 1.5
        '{1'b0, 16'h0000, 55'h40000000000000, 64'h4350000000000000}, // R1 e=0
        '{1'b0, 16'hFFCA, 55'h40000000000005, 64'h3FF0000000000001}, // R2 101
        '{1'b0, 16'hFFCA, 55'h40000000000003, 64'h3FF0000000000001}, // R3 011
        '{1'b0, 16'hFFCA, 55'h40000000000002, 64'h3FF0000000000000}, // R4 even tie
        '{1'b0, 16'hFFCA, 55'h40000000000006, 64'h3FF0000000000002}, // R4 odd tie
        '{1'b0, 16'hFFCA, 55'h7FFFFFFFFFFFFF, 64'h4000000000000000}, // R5 carry
        '{1'b0, 16'hFBCB, 55'h40000000000000, 64'h0000000000000000}, // R6 -1077
        '{1'b1, 16'hFBCB, 55'h7FFFFFFFFFFFFF, 64'h8000000000000000}, // R6 -1077 neg
        '{1'b0, 16'hFBCC, 55'h40000000000000, 64'h0010000000000000}, // R7 -1076
        '{1'b1, 16'h0005, 55'h00000000000000, 64'h8000000000000000}, // R8 -0
        '{1'b0, 16'h0005, 55'h00000000000000, 64'h0000000000000000}  // R8 +0
    };

    function automatic logic [63:0] ref_pack(input logic s, input logic signed [15:0] e,
                                             input logic [54:0] m);
        int          be;
        logic [52:0] frac;
        logic        up;
        if (int'(e) < -1076 || m == '0) return {s, 63'd0};
        be   = int'(e) + 1077;
        up   = m[1] & (m[0] | m[2]);
        frac = {1'b0, m[53:2]} + 53'(up);
        if (frac[52]) be = be + 1;
        return {s, be[10:0], frac[51:0]};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic s, input logic [15:0] e, input logic [54:0] m);
        @(negedge clk);
        in_sign  = s;
        in_exp   = e;
        in_mant  = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_mant = '0;
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", 64'(out_valid), 64'd0);
        check("R9 reset out_data", out_data, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].s, VECS[i].e, VECS[i].m);
            check($sformatf("R1-table vec %0d", i), out_data, VECS[i].x);
            check($sformatf("R9 valid vec %0d", i), 64'(out_valid), 64'd1);
            check($sformatf("R1 ref vec %0d", i), out_data,
                  ref_pack(VECS[i].s, VECS[i].e, VECS[i].m));
        end

        // R10: idle cycle with changed inputs leaves the word alone
        @(negedge clk);
        in_sign = 1'b1; in_exp = 16'h0010; in_mant = 55'h7FFFFFFFFFFFFF;
        @(negedge clk);
        check("R10 hold data", out_data, VECS[NV-1].x);
        check("R9 idle valid low", 64'(out_valid), 64'd0);

        // R1..R4 sweep against the reference
        for (int k = 0; k < 300; k++) begin
            logic [54:0] m;
            logic signed [15:0] e;
            m  = {1'b1, 22'($urandom), 32'($urandom)};
            e  = 16'(int'($urandom_range(0, 2000)) - 1100);
            apply(k[0], e, m);
            check("R1 sweep", out_data, ref_pack(k[0], e, m));
        end

        // R9: back-to-back words then reset clears
        @(negedge clk);
        in_valid = 1'b1; in_sign = 1'b0; in_exp = 16'hFFCA; in_mant = 55'h40000000000000;
        @(negedge clk);
        in_mant = 55'h60000000000000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second word", out_data, 64'h3FF8000000000000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset clears data", out_data, 64'd0);
        check("R9 reset clears valid", 64'(out_valid), 64'd0);

        finish_run();
    end

endmodule